// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block takes the two phase signals of an incremental encoder and turns each counted transition into a pulse on one of two separate active-low outputs. One output is for forward motion and the other is for reverse motion. These outputs can drive an ordinary up/down counter with no further decoding. Before the phase signals are decoded, each one passes through its own synchronizer and a stability filter. These remove metastability, electrical noise and dither around an edge.

A two-bit resolution input chooses which transitions are counted: all four edges of a cycle, only the edges of phase A, or only the rising edge of phase A. A width input sets how many system clocks each pulse lasts. A third active-low output pulses whenever either direction pulses. A transition in which both filtered phases change in the same clock is illegal. It produces no pulse and raises a one-cycle flag.

A pulse begins `SYNC_STAGES + FILT_CYCLES + 1` clock edges after a raw input change that is clean.

Top module: `quad_pulse_conv`

## Requirements
- R1: When `rst_n` is sampled low, `up_n`, `down_n` and `step_n` are high and `bad_step` is low at the next edge. The filtered phase state is loaded from the synchronized inputs, so releasing reset while the inputs are steady produces no pulse.
- R2: A filtered phase takes a new level only after its synchronized input has differed from it on `FILT_CYCLES` consecutive clock edges. A shorter excursion produces no pulse.
- R3: With `res_mode` = 2'b10 or 2'b11, every filtered edge of A and every filtered edge of B produces one pulse.
- R4: With `res_mode` = 2'b01, only filtered edges of A produce pulses. Edges of B produce none.
- R5: With `res_mode` = 2'b00, only a filtered rising edge of A produces a pulse.
- R6: A pulse is forward (on `up_n`) when A leads B. For an A edge this means the new A differs from B. For a B edge it means the new B equals A. In every other case the pulse is reverse (on `down_n`).
- R7: A pulse holds its output low for `pulse_len` clock cycles. A `pulse_len` of 0 is treated as 1.
- R8: A counted edge that arrives while a pulse is active restarts the pulse, for a full width, in the direction of the new edge.
- R9: When both filtered phases change on the same edge, no pulse starts and `bad_step` is high for exactly one cycle.
- R10: `step_n` is low exactly when `up_n` or `down_n` is low.
- R11: `up_n` and `down_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Raw phase A from the encoder, asynchronous |
| enc_b | input | 1 | Raw phase B from the encoder, asynchronous |
| res_mode | input | 2 | Resolution: 00 = x1, 01 = x2, 1x = x4 |
| pulse_len | input | WIDTH_W | Output pulse length in clock cycles (0 behaves as 1) |
| up_n | output | 1 | Forward count pulse, active low |
| down_n | output | 1 | Reverse count pulse, active low |
| step_n | output | 1 | Combined count pulse, active low |
| bad_step | output | 1 | One-cycle flag for an illegal double-phase change |

## Verification
The bench builds the block with `FILT_CYCLES` = 3, `SYNC_STAGES` = 2 and `WIDTH_W` = 4. A filter depth of 3 makes a two-cycle glitch a short, exact case of rejection. The 4-bit width allows the largest legal length, 15, as well as 0, so both ends of the length range are exercised. Edges in the retrigger case are spaced four cycles apart, so a restart in the opposite direction is seen with the first pulse cut to a known length.

// File: rtl/qpc_pkg.sv
// Package: shared encodings for the quadrature pulse converter.
// Assumes the resolution input is two bits wide; bit 1 set means x4.
package qpc_pkg;

    typedef enum logic [1:0] {
        RES_X1 = 2'b00,
        RES_X2 = 2'b01,
        RES_X4 = 2'b10
    } res_e;

    // Fold the two-bit resolution code onto the three resolutions.
    function automatic res_e decode_res(input logic [1:0] code);
        if (code[1])
            return RES_X4;
        else if (code[0])
            return RES_X2;
        else
            return RES_X1;
    endfunction

endpackage

// File: rtl/qpc_filter.sv
// Module: qpc_filter
// Synchronizes one asynchronous phase input. The filtered level changes
// only after the synchronized value has differed from it on CYCLES
// consecutive clock edges. While in reset, the filtered level follows the
// synchronized input, so the decoder starts from the real input state.
// Assumes CYCLES >= 2 and STAGES >= 2.
module qpc_filter #(
    parameter int STAGES = 2,
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     run_q;
    logic              level_q;

    // Synchronizer chain; plain data flops, not reset.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) sync_q[0] <= raw;
            end else begin : g_next
                always_ff @(posedge clk) sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    // Stability counter: accept a new level after CYCLES differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= sync_q[STAGES-1];
            run_q   <= '0;
        end else if (sync_q[STAGES-1] != level_q) begin
            if (run_q == LAST) begin
                level_q <= sync_q[STAGES-1];
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/qpc_decode.sv
// Module: qpc_decode
// Compares the filtered phases with their values from the previous cycle.
// It flags a counted edge for the selected resolution and gives the edge's
// direction. A change on both phases in the same cycle is rejected and
// reported for one cycle. Assumes its inputs come from qpc_filter.
module qpc_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fa,
    input  logic       fb,
    input  logic [1:0] res_mode,
    output logic       evt,
    output logic       evt_up,
    output logic       bad
);
    logic pa_q, pb_q, bad_q;
    logic a_chg, b_chg, both;
    res_e res;

    // Previous filtered levels; loaded from the live levels during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q <= fa;
            pb_q <= fb;
        end else begin
            pa_q <= fa;
            pb_q <= fb;
        end
    end

    // Edge classification by resolution, plus the direction rule.
    always_comb begin
        res    = decode_res(res_mode);
        a_chg  = fa ^ pa_q;
        b_chg  = fb ^ pb_q;
        both   = a_chg & b_chg;
        evt    = 1'b0;
        evt_up = 1'b0;
        if (!both) begin
            if (a_chg) begin
                evt_up = (fa != fb);
                case (res)
                    RES_X1:  evt = fa;
                    default: evt = 1'b1;
                endcase
            end else if (b_chg) begin
                evt_up = (fb == fa);
                evt    = (res == RES_X4);
            end
        end
    end

    // One-cycle flag for an illegal double change.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_q <= 1'b0;
        else        bad_q <= both;
    end

    assign bad = bad_q;
endmodule

// File: rtl/qpc_pulse.sv
// Module: qpc_pulse
// Stretches each counted edge into an active-low pulse of the requested
// length, routed by direction. A new edge reloads the length and takes
// the new direction. Assumes evt is a one-cycle strobe.
module qpc_pulse #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic               evt_up,
    input  logic [WIDTH_W-1:0] len,
    output logic               up_n,
    output logic               down_n
);
    logic [WIDTH_W-1:0] left_q;
    logic [WIDTH_W-1:0] load;
    logic               dir_q;

    // A length of zero is lifted to one cycle.
    always_comb load = (len == '0) ? WIDTH_W'(1) : len;

    // Remaining-cycle counter and latched direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            dir_q  <= 1'b0;
        end else if (evt) begin
            left_q <= load;
            dir_q  <= evt_up;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign up_n   = !((left_q != '0) &&  dir_q);
    assign down_n = !((left_q != '0) && !dir_q);
endmodule

// File: rtl/quad_pulse_conv.sv
// Module: quad_pulse_conv (top)
// Turns two quadrature phases into separate active-low forward and reverse
// pulse trains, plus a combined pulse and an illegal-transition flag.
// Assumes asynchronous phase inputs and that pulse_len is no longer than
// the spacing between phase edges.
module quad_pulse_conv #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 4,
    parameter int WIDTH_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [1:0]         res_mode,
    input  logic [WIDTH_W-1:0] pulse_len,
    output logic               up_n,
    output logic               down_n,
    output logic               step_n,
    output logic               bad_step
);
    logic fa, fb, evt, evt_up;

    qpc_filter #(.STAGES(SYNC_STAGES), .CYCLES(FILT_CYCLES)) u_filt_a (
        .clk(clk), .rst_n(rst_n), .raw(enc_a), .level(fa)
    );

    qpc_filter #(.STAGES(SYNC_STAGES), .CYCLES(FILT_CYCLES)) u_filt_b (
        .clk(clk), .rst_n(rst_n), .raw(enc_b), .level(fb)
    );

    qpc_decode u_dec (
        .clk(clk), .rst_n(rst_n), .fa(fa), .fb(fb), .res_mode(res_mode),
        .evt(evt), .evt_up(evt_up), .bad(bad_step)
    );

    qpc_pulse #(.WIDTH_W(WIDTH_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_up(evt_up),
        .len(pulse_len), .up_n(up_n), .down_n(down_n)
    );

    // Combined count pulse.
    assign step_n = up_n & down_n;
endmodule

// File: rtl/qpc_checker.sv
// Module: qpc_checker
// Properties over the converter's outputs; attached to every instance of
// quad_pulse_conv by the bind below.
module qpc_checker (
    input logic clk,
    input logic rst_n,
    input logic up_n,
    input logic down_n,
    input logic step_n,
    input logic bad_step
);
    // R1: a sampled reset leaves every output inactive at the next edge.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (up_n && down_n && step_n && !bad_step));

    // R11: the two directions are never active together.
    a_r11_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!up_n && !down_n));

    // R9: the illegal flag lasts a single cycle.
    a_r9_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        bad_step |=> !bad_step);

    // R9: no pulse begins in the cycle the illegal flag is raised.
    a_r9_no_pulse_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bad_step |-> !($fell(up_n) || $fell(down_n)));

    // R10: the combined pulse falls only when one direction is active.
    a_r10_step_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_n) |-> (!up_n || !down_n));
endmodule

bind quad_pulse_conv qpc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .down_n(down_n),
    .step_n(step_n), .bad_step(bad_step)
);

// File: tb/quad_pulse_conv_test.sv
module quad_pulse_conv_test;
    localparam int SYNC = 2;
    localparam int FILT = 3;
    localparam int WW   = 4;

    typedef struct {
        int    kind;   // 0 forward, 1 reverse, 2 illegal flag
        int    len;
        string req;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0]    res_mode = 2'b10;
    logic [WW-1:0] pulse_len = 4'd3;
    logic up_n, down_n, step_n, bad_step;

    int    checks = 0, fails = 0;
    item_t sb[$];
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    quad_pulse_conv #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT), .WIDTH_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .res_mode(res_mode), .pulse_len(pulse_len),
        .up_n(up_n), .down_n(down_n), .step_n(step_n), .bad_step(bad_step)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_item(input int kind, input int len, input string req);
        item_t it;
        it.kind = kind; it.len = len; it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drive new phase levels, queue the expected result and wait for it to settle.
    task automatic step(input logic a, input logic b, input int kind, input string req);
        int w;
        w = (pulse_len == 0) ? 1 : int'(pulse_len);
        enc_a = a; enc_b = b;
        if (kind >= 0) expect_item(kind, (kind == 2) ? 1 : w, req);
        idle(SYNC + FILT + w + 4);
    endtask

    // Monitor: measure each pulse and compare it with the scoreboard.
    int  run_kind = -1, run_len = 0;
    bit  comb_ok = 1'b1;
    always @(negedge clk) begin
        int cur;
        item_t it;
        if (rst_n) begin
            cur = !up_n ? 0 : (!down_n ? 1 : -1);
            if (cur != run_kind) begin
                if (run_kind >= 0) begin
                    if (sb.size() == 0) check(0, "R2 unexpected pulse", run_kind, -1);
                    else begin
                        it = sb.pop_front();
                        check(it.kind == run_kind, {it.req, " direction"}, run_kind, it.kind);
                        check(it.len == run_len, {it.req, " length"}, run_len, it.len);
                        check(comb_ok, "R10 combined pulse", 0, 1);
                    end
                end
                run_len = 1;
                comb_ok = (cur < 0) || !step_n;
            end else if (cur >= 0) begin
                run_len++;
                if (step_n) comb_ok = 1'b0;
            end
            run_kind = cur;
            if (cur < 0 && !step_n) check(0, "R10 combined idle", 0, 1);
            if (bad_step) begin
                if (sb.size() == 0) check(0, "R9 unexpected flag", 2, -1);
                else begin
                    it = sb.pop_front();
                    check(it.kind == 2, {it.req, " flag"}, 2, it.kind);
                end
            end
        end
    end

    initial begin
        fork
            begin
                // R1: reset with non-zero phases; release must give no pulse.
                enc_a = 1'b1; enc_b = 1'b0;
                idle(8);
                check(up_n && down_n && step_n && !bad_step, "R1 reset outputs", {up_n, down_n, step_n, bad_step}, 4'b1110);
                rst_n = 1'b1;
                idle(12);
                check(sb.size() == 0 && up_n && down_n, "R1 no pulse on release", {up_n, down_n}, 2'b11);
                step(1'b0, 1'b0, 1, "R6 reverse fall A");

                // R3 and R6: full forward and reverse cycles at x4.
                res_mode = 2'b10; pulse_len = 4'd3;
                step(1'b1, 1'b0, 0, "R3 fwd A rise");
                step(1'b1, 1'b1, 0, "R3 fwd B rise");
                step(1'b0, 1'b1, 0, "R6 fwd A fall");
                step(1'b0, 1'b0, 0, "R6 fwd B fall");
                res_mode = 2'b11;
                step(1'b0, 1'b1, 1, "R3 rev B rise");
                step(1'b1, 1'b1, 1, "R6 rev A rise");
                step(1'b1, 1'b0, 1, "R6 rev B fall");
                step(1'b0, 1'b0, 1, "R3 rev A fall");

                // R4: x2 counts A edges only.
                res_mode = 2'b01;
                step(1'b1, 1'b0, 0, "R4 A rise");
                step(1'b1, 1'b1, -1, "R4 B ignored");
                step(1'b0, 1'b1, 0, "R4 A fall");
                step(1'b0, 1'b0, -1, "R4 B ignored");

                // R5: x1 counts rising A only.
                res_mode = 2'b00;
                step(1'b1, 1'b0, 0, "R5 fwd rise");
                step(1'b1, 1'b1, -1, "R5 B ignored");
                step(1'b0, 1'b1, -1, "R5 A fall ignored");
                step(1'b1, 1'b1, 1, "R5 rev rise");
                step(1'b1, 1'b0, -1, "R5 B ignored");
                step(1'b0, 1'b0, -1, "R5 A fall ignored");

                // R7: length extremes.
                res_mode = 2'b10;
                pulse_len = 4'd0;
                step(1'b1, 1'b0, 0, "R7 zero length");
                pulse_len = 4'd15;
                step(1'b1, 1'b1, 0, "R7 max length");

                // R2: a glitch shorter than the filter gives nothing.
                pulse_len = 4'd3;
                enc_a = 1'b0; idle(FILT - 1); enc_a = 1'b1;
                idle(20);
                check(sb.size() == 0 && up_n && down_n, "R2 glitch rejected", {up_n, down_n}, 2'b11);

                // R9: both phases together.
                step(1'b0, 1'b0, 2, "R9 illegal 11->00");
                step(1'b1, 1'b1, 2, "R9 illegal 00->11");
                idle(5);
                check(up_n && down_n, "R9 no pulse after illegal", {up_n, down_n}, 2'b11);
                step(1'b0, 1'b1, 0, "R6 fwd A fall");
                step(1'b0, 1'b0, 0, "R6 fwd B fall");

                // R8: restart in the opposite direction 4 cycles in.
                pulse_len = 4'd10;
                expect_item(0, 4, "R8 cut forward");
                enc_a = 1'b1;
                idle(4);
                expect_item(1, 10, "R8 restarted reverse");
                enc_a = 1'b0;
                idle(30);

                check(sb.size() == 0, "R3 all expected pulses seen", sb.size(), 0);
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) check(0, "watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule